// File: doc/BRIEF.md
# Voltage and Clock Level Change Sequencer

This block steps one processor domain from its present performance level to a newly requested level. A single-cycle write names the target level. The block compares that level with the level it holds as current and picks a direction. It looks up the supply code paired with the target in a small table that is loaded through registers. Then it drives a regulator load strobe and a clock generator load strobe, one after the other. After each strobe it waits for that device to settle.

When the level rises, the supply is raised before the clock speeds up. When the level falls, the clock slows down before the supply is lowered. Each wait ends when the device's ready input is seen, or when a programmable cycle budget runs out. If the budget runs out, a sticky error flag is set and the sequence carries on.

A request that arrives while a change is in progress is held. The newest held request starts once the running sequence ends. A request for the level already in force finishes at once and touches neither device.

Top module: `dvfs_seq_top`

## Requirements
- R1: After reset, `busy`, `done` and `timeout_err` are 0, `cur_level` and `clk_level` are 0, and `vreg_code` is 16. Table entry i resets to the code 16 + 4*i.
- R2: A cycle with `tbl_we` high stores `tbl_code` into entry `tbl_idx`. Later sequences that target that level issue the stored code on `vreg_code`.
- R3: Upward change (target level numerically above `cur_level`): `vreg_load` pulses first with the target's code on `vreg_code`. After the supply settles, `clk_load` pulses with the target on `clk_level`.
- R4: Downward change: `clk_load` pulses first with the target level. After the clock settles, `vreg_load` pulses with the target's code.
- R5: A request equal to `cur_level` pulses `done` in the cycle after the write. `busy` stays 0 and neither load strobe pulses.
- R6: If the ready input of the device just loaded is high d cycles after its load cycle (d at least 1), the next strobe, or `done`, comes d+1 cycles after that load.
- R7: If ready never comes, the next strobe, or `done`, comes L+2 cycles after the load, where L is `settle_limit`. `timeout_err` is then set and stays 1 until reset.
- R8: `busy` is 1 from the cycle after a differing request is accepted until the `done` cycle. `cur_level` takes the target value in that `done` cycle and at no other time.
- R9: Requests written while `busy` is 1 are held, and the last one wins. The held request starts after the running sequence's `done`, measured against the updated `cur_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Level whose supply code is written |
| tbl_code | input | 6 | Supply code to store |
| req_we | input | 1 | Level request strobe |
| req_level | input | 3 | Requested performance level |
| settle_limit | input | 16 | Settle budget in cycles |
| vreg_load | output | 1 | Regulator load strobe |
| vreg_code | output | 6 | Supply code for the regulator |
| vreg_ready | input | 1 | Regulator settled indication |
| clk_load | output | 1 | Clock generator load strobe |
| clk_level | output | 3 | Level for the clock generator |
| clk_locked | input | 1 | Clock generator settled indication |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_level | output | 3 | Level currently in force |
| timeout_err | output | 1 | Sticky settle timeout flag |

## Verification
The assertions assume that `settle_limit` and the table stay fixed while `busy` is 1. They also assume that each ready input is low in the load cycle and rises only in answer to a strobe. The bench honours both. It rewrites the table and changes the budget only when the block is idle. Its device models drive ready as one short pulse a chosen number of cycles after the matching strobe, or never drive it, to force a timeout.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE1,
    SQ_WAIT1,
    SQ_ISSUE2,
    SQ_WAIT2
  } seq_state_e;

  // Supply code held by table entry idx after reset.
  function automatic int unsigned reset_vcode(int unsigned idx);
    return 16 + 4 * idx;
  endfunction

  // Going up the supply moves first; going down it moves second.
  function automatic logic step_is_volt(logic going_up, logic second_step);
    return going_up ^ second_step;
  endfunction

  // The settle budget is used up once the counter reaches the limit.
  function automatic logic limit_hit(logic [31:0] cnt, logic [31:0] limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/dvfs_vtable.sv
module dvfs_vtable
  import dvfs_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [LVL_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code
);
  localparam int LEVELS = 1 << LVL_W;

  logic [CODE_W-1:0] tbl [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[g] <= CODE_W'(reset_vcode(g));
      else if (wr_en && wr_idx == LVL_W'(g))
        tbl[g] <= wr_code;
    end
  end

  assign rd_code = tbl[rd_idx];

  assert_tbl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_idx)] == $past(wr_code));

endmodule

// File: rtl/dvfs_settle.sv
module dvfs_settle
  import dvfs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  input  logic [CNT_W-1:0] limit,
  output logic             fin,
  output logic             expired
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             budget_out;

  assign budget_out = limit_hit(32'(cnt), 32'(limit));
  assign fin        = active && (ready || budget_out);
  assign expired    = active && !ready && budget_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (fin) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt <= limit);

  assert_fin_ends_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !start |=> !active);

endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
  import dvfs_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [LVL_W-1:0]  req_level,
  output logic [LVL_W-1:0]  lookup_idx,
  input  logic [CODE_W-1:0] lookup_code,
  input  logic              settle_fin,
  input  logic              settle_expired,
  output logic              settle_start,
  output logic              settle_on_volt,
  output logic              vreg_load,
  output logic [CODE_W-1:0] vreg_code,
  output logic              clk_load,
  output logic [LVL_W-1:0]  clk_level,
  output logic              busy,
  output logic              done,
  output logic [LVL_W-1:0]  cur_level,
  output logic              timeout_err
);
  seq_state_e        state;
  logic              pend_valid;
  logic [LVL_W-1:0]  pend_level;
  logic [LVL_W-1:0]  tgt_level;
  logic [CODE_W-1:0] tgt_code;
  logic              going_up;
  logic [CODE_W-1:0] code_q;
  logic [LVL_W-1:0]  freq_q;

  // Named events used by the logic and the assertions.
  logic              in_idle, take, same_level, issue, second, volt_step, seq_end;
  logic [LVL_W-1:0]  accept_level;

  assign in_idle      = (state == SQ_IDLE);
  assign accept_level = req_we ? req_level : pend_level;
  assign take         = in_idle && (req_we || pend_valid);
  assign same_level   = (accept_level == cur_level);
  assign issue        = (state == SQ_ISSUE1) || (state == SQ_ISSUE2);
  assign second       = (state == SQ_ISSUE2) || (state == SQ_WAIT2);
  assign volt_step    = step_is_volt(going_up, second);
  assign seq_end      = (state == SQ_WAIT2) && settle_fin;

  assign lookup_idx     = accept_level;
  assign settle_start   = issue;
  assign settle_on_volt = volt_step;
  assign vreg_load      = issue && volt_step;
  assign clk_load       = issue && !volt_step;
  assign vreg_code      = vreg_load ? tgt_code : code_q;
  assign clk_level      = clk_load ? tgt_level : freq_q;
  assign busy           = !in_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_level <= '0;
    end else if (req_we && !in_idle) begin
      pend_valid <= 1'b1;
      pend_level <= req_level;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      tgt_level <= '0;
      tgt_code  <= '0;
      going_up  <= 1'b0;
      cur_level <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (take) begin
          if (same_level) begin
            done <= 1'b1;
          end else begin
            tgt_level <= accept_level;
            tgt_code  <= lookup_code;
            going_up  <= accept_level > cur_level;
            state     <= SQ_ISSUE1;
          end
        end
        SQ_ISSUE1: state <= SQ_WAIT1;
        SQ_WAIT1:  if (settle_fin) state <= SQ_ISSUE2;
        SQ_ISSUE2: state <= SQ_WAIT2;
        SQ_WAIT2:  if (settle_fin) begin
          cur_level <= tgt_level;
          done      <= 1'b1;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q      <= CODE_W'(reset_vcode(0));
      freq_q      <= '0;
      timeout_err <= 1'b0;
    end else begin
      if (vreg_load) code_q <= tgt_code;
      if (clk_load)  freq_q <= tgt_level;
      if (settle_expired) timeout_err <= 1'b1;
    end
  end

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(vreg_load && clk_load));

  assert_volt_before_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_load && going_up |-> vreg_code == tgt_code);

  assert_clk_before_volt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_load && !going_up |-> clk_level == tgt_level);

  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(vreg_load || clk_load));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

  assert_level_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> done);

  assert_pending_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && pend_valid && !req_we && !same_level |=> busy);

endmodule

// File: rtl/dvfs_seq_top.sv
module dvfs_seq_top
  import dvfs_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int CODE_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [LVL_W-1:0]  tbl_idx,
  input  logic [CODE_W-1:0] tbl_code,
  input  logic              req_we,
  input  logic [LVL_W-1:0]  req_level,
  input  logic [CNT_W-1:0]  settle_limit,
  output logic              vreg_load,
  output logic [CODE_W-1:0] vreg_code,
  input  logic              vreg_ready,
  output logic              clk_load,
  output logic [LVL_W-1:0]  clk_level,
  input  logic              clk_locked,
  output logic              busy,
  output logic              done,
  output logic [LVL_W-1:0]  cur_level,
  output logic              timeout_err
);
  logic [LVL_W-1:0]  lookup_idx;
  logic [CODE_W-1:0] lookup_code;
  logic              settle_start, settle_on_volt, settle_fin, settle_expired;
  logic              settle_ready;

  assign settle_ready = settle_on_volt ? vreg_ready : clk_locked;

  dvfs_vtable #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_vtable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_code (tbl_code),
    .rd_idx  (lookup_idx),
    .rd_code (lookup_code)
  );

  dvfs_settle #(.CNT_W(CNT_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (settle_start),
    .ready   (settle_ready),
    .limit   (settle_limit),
    .fin     (settle_fin),
    .expired (settle_expired)
  );

  dvfs_ctrl #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_we         (req_we),
    .req_level      (req_level),
    .lookup_idx     (lookup_idx),
    .lookup_code    (lookup_code),
    .settle_fin     (settle_fin),
    .settle_expired (settle_expired),
    .settle_start   (settle_start),
    .settle_on_volt (settle_on_volt),
    .vreg_load      (vreg_load),
    .vreg_code      (vreg_code),
    .clk_load       (clk_load),
    .clk_level      (clk_level),
    .busy           (busy),
    .done           (done),
    .cur_level      (cur_level),
    .timeout_err    (timeout_err)
  );

endmodule

// File: tb/test_dvfs_seq_top.sv
module test_dvfs_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [5:0]  tbl_code = '0;
  logic        req_we = 1'b0;
  logic [2:0]  req_level = '0;
  logic [15:0] settle_limit = 16'd200;
  logic        vreg_ready = 1'b0;
  logic        clk_locked = 1'b0;
  logic        vreg_load, clk_load, busy, done, timeout_err;
  logic [5:0]  vreg_code;
  logic [2:0]  clk_level, cur_level;

  dvfs_seq_top i_dvfs_seq_top (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_code(tbl_code),
    .req_we(req_we), .req_level(req_level), .settle_limit(settle_limit),
    .vreg_load(vreg_load), .vreg_code(vreg_code), .vreg_ready(vreg_ready),
    .clk_load(clk_load), .clk_level(clk_level), .clk_locked(clk_locked),
    .busy(busy), .done(done), .cur_level(cur_level), .timeout_err(timeout_err));

  always #2 clk = ~clk;

  typedef struct { int kind; int val; int gap; string tag; } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0, cyc = 0, last_load = 0;
  int vdly = 1, fdly = 1, cur_m = 0;
  int tbl_m [8];
  bit finished = 0;

  initial forever begin @(posedge clk); cyc++; end

  task automatic chk(bit ok, string tag, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int gap_of(int d);
    return (d == 0) ? int'(settle_limit) + 2 : d + 1;
  endfunction

  task automatic push(int kind, int val, int gap, string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: kind 0 = supply strobe, 1 = clock strobe, 2 = done.
  task automatic take(int kind, int val);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "R8 unexpected event", kind, -1);
      return;
    end
    e = q.pop_front();
    chk(e.kind == kind, {e.tag, " event kind"}, kind, e.kind);
    chk(e.val == val, {e.tag, " value"}, val, e.val);
    if (e.gap >= 0) chk(cyc - last_load == e.gap, {e.tag, " settle gap R6/R7"}, cyc - last_load, e.gap);
    if (kind != 2) last_load = cyc;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (vreg_load) take(0, int'(vreg_code));
      if (clk_load)  take(1, int'(clk_level));
      if (done)      take(2, int'(cur_level));
    end
  end

  // Device models: one ready pulse d cycles after the strobe; d = 0 means never.
  initial forever begin
    @(negedge clk);
    if (vreg_load && vdly != 0) begin
      repeat (vdly) @(negedge clk);
      vreg_ready = 1'b1;
      @(negedge clk);
      vreg_ready = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (clk_load && fdly != 0) begin
      repeat (fdly) @(negedge clk);
      clk_locked = 1'b1;
      @(negedge clk);
      clk_locked = 1'b0;
    end
  end

  task automatic wr_req(int lvl);
    @(negedge clk);
    req_we = 1'b1; req_level = 3'(lvl);
    @(negedge clk);
    req_we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_seq(int from, int to, string tag);
    if (to == from) push(2, to, -1, {tag, " R5"});
    else if (to > from) begin
      push(0, tbl_m[to], -1, {tag, " R3 supply first"});
      push(1, to, gap_of(vdly), {tag, " R3 clock second"});
      push(2, to, gap_of(fdly), {tag, " R8 done"});
    end else begin
      push(1, to, -1, {tag, " R4 clock first"});
      push(0, tbl_m[to], gap_of(fdly), {tag, " R4 supply second"});
      push(2, to, gap_of(vdly), {tag, " R8 done"});
    end
  endtask

  task automatic run_seq(int to, int vd, int fd, string tag);
    vdly = vd; fdly = fd;
    expect_seq(cur_m, to, tag);
    wr_req(to);
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    cur_m = to;
    drain();
    chk(busy == 1'b0, "R8 busy cleared", int'(busy), 0);
    chk(int'(cur_level) == to, "R8 current level", int'(cur_level), to);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tbl_m[i] = 8 + 5 * i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done", int'({busy, done}), 0);
    chk(timeout_err == 0, "R1 error flag", int'(timeout_err), 0);
    chk(cur_level == 0 && clk_level == 0, "R1 levels", int'({cur_level, clk_level}), 0);
    chk(vreg_code == 6'd16, "R1 supply code", int'(vreg_code), 16);

    // R2: load the table
    for (int i = 0; i < 8; i++) begin
      tbl_we = 1'b1; tbl_idx = 3'(i); tbl_code = 6'(tbl_m[i]);
      @(negedge clk);
    end
    tbl_we = 1'b0;
    @(negedge clk);

    run_seq(5, 3, 4, "up 0-5");
    vdly = 1; fdly = 1;
    push(2, 5, -1, "equal R5");
    wr_req(5);
    chk(done == 1'b1, "R5 done next cycle", int'(done), 1);
    chk(busy == 1'b0, "R5 busy stays low", int'(busy), 0);
    drain();
    run_seq(1, 2, 6, "down 5-1");
    run_seq(7, 1, 1, "up 1-7");
    chk(timeout_err == 0, "R7 no error yet", int'(timeout_err), 0);

    settle_limit = 16'd20;
    run_seq(2, 0, 3, "timeout 7-2 R7");
    chk(timeout_err == 1, "R7 error set", int'(timeout_err), 1);
    settle_limit = 16'd200;
    run_seq(6, 5, 2, "up 2-6");
    chk(timeout_err == 1, "R7 error sticky", int'(timeout_err), 1);

    // R9: held requests, latest wins
    vdly = 6; fdly = 6;
    expect_seq(6, 4, "first R9");
    expect_seq(4, 3, "held R9");
    wr_req(4);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R9 busy while held", int'(busy), 1);
    wr_req(1);
    wr_req(3);
    cur_m = 3;
    drain();
    chk(int'(cur_level) == 3, "R9 final level", int'(cur_level), 3);
    chk(busy == 1'b0, "R9 idle at end", int'(busy), 0);
    chk(q.size() == 0, "R9 all events seen", q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule